// File: doc/BRIEF.md
# Serial ADC Sample Reader (Host Side)

This block is the host end of a three-wire link to a 10-bit successive-approximation converter. It drives an active-low chip select and a serial clock, produced from the system clock by a programmable divider, and it shifts in the converter's serial data line. A conversion starts when chip select falls. The converter then sends sixteen bits: three zero bits, the ten result bits with the most significant bit first, and trailing zeros. The block collects those bits, strips the framing and hands the 10-bit code to the system with a one-cycle valid strobe.

A request is a one-cycle `start` pulse, or `continuous` held high for back-to-back samples. All link timing is counted in system clocks from nanosecond parameters. This covers the acquisition window after the 13th rising serial clock edge, the quiet time with chip select high, and a minimum frame period that gives a throughput of the serial clock rate over the frame length. When `low_power` is set, every real read is followed by a deliberately short frame that puts the converter into shutdown. The first conversion after reset, or after any shutdown, is a dummy: the block runs it and discards it.

Top module: `adc_sample_reader`

## Requirements
- R1: After reset `cs_n` and `sclk` are high, `busy` is low and `result_valid` is low.
- R2: `sclk` idles high and only toggles while `cs_n` is low. `cs_n` falls only while `sclk` is high, so the first serial edge of a frame is falling, and it comes at least `SCLK_HALF` clocks after the fall. A full frame has exactly 16 falling edges.
- R3: The bit on `sdata` is captured at each rising `sclk` edge. Captured bits 4 to 13 (bit 1 is the first captured) form `result`, MSB first. `result_valid` is a single-cycle pulse, and `result` changes only together with it.
- R4: `frame_error` is updated with each result and is 1 when any of captured bits 1 to 3 is 1, otherwise 0.
- R5: `cs_n` stays high for at least ceil(`QUIET_NS` / clock period) clocks between frames.
- R6: At least ceil(`ACQ_NS` / clock period) clocks pass between the 13th rising `sclk` edge of a frame and the next fall of `cs_n`.
- R7: Successive falls of `cs_n` are at least `FRAME_SCLKS`*2*`SCLK_HALF` clocks apart.
- R8: The first conversion after reset, and the first after a shutdown frame, is a full 16-edge dummy frame whose data is never reported. The real frame follows it.
- R9: With `low_power` high, each reported frame is followed by a frame that raises `cs_n` after exactly `SHDN_EDGES` falling edges (2 to 9). This leaves the converter in shutdown.
- R10: While `continuous` is high, a new read is started after every result without any `start` pulse.
- R11: `busy` is high from the accepted request until its last frame (including a shutdown frame) has ended. A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request for a single sample |
| continuous | input | 1 | Keep sampling back to back while high |
| low_power | input | 1 | Shut the converter down after each sample |
| sclk | output | 1 | Serial clock to the converter, idles high |
| cs_n | output | 1 | Active-low chip select |
| sdata | input | 1 | Serial data from the converter |
| busy | output | 1 | A request or frame is in progress |
| result | output | DATA_W | Last converted code |
| result_valid | output | 1 | One-cycle strobe for a new `result` |
| frame_error | output | 1 | Leading bits of the last result frame were not zero |

## Verification
The hardest state to reach is the discard of a dummy conversion after a shutdown. The converter must first have been put to sleep by a short frame, and only then can the block be seen running dummy, real and shutdown frames in sequence for one request. The bench contains a behavioural converter that tracks its own power state from the number of falling edges seen before chip select rises. It sends a marker code whenever it converts from sleep. It runs a low-power read from the awake state, then a second one from the sleeping state, and counts frames and edges. The scoreboard rejects the marker code if it ever reaches `result`.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [1:0] {
    FR_DUMMY = 2'd0,
    FR_REAL  = 2'd1,
    FR_SHDN  = 2'd2
  } frame_kind_e;

  // number of system clocks that cover ns nanoseconds, rounded up
  function automatic int ns_to_clks(input int ns, input int clk_hz);
    return (ns * (clk_hz / 1000) + 999_999) / 1_000_000;
  endfunction

endpackage

// File: rtl/adc_rd_sat_timer.sv
module adc_rd_sat_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= W'(LIMIT);
    else if (clr)               cnt <= '0;
    else if (cnt != W'(LIMIT))  cnt <= cnt + W'(1);
  end

  assign done = (cnt == W'(LIMIT));
endmodule

// File: rtl/adc_rd_sclk_eng.sv
module adc_rd_sclk_eng #(
  parameter int HALF   = 7,
  parameter int WORD   = 16,
  parameter int CAP_W  = 13
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          go,
  input  logic [$clog2(WORD+1)-1:0]     n_edges,
  input  logic                          sdata,
  output logic                          sclk,
  output logic                          cs_n,
  output logic                          track_pulse,
  output logic                          done,
  output logic [CAP_W-1:0]              cap
);
  localparam int DW = $clog2(HALF + 1);
  localparam int EW = $clog2(WORD + 1);

  logic          active;
  logic [DW-1:0] div;
  logic [EW-1:0] rises;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk        <= 1'b1;
      cs_n        <= 1'b1;
      active      <= 1'b0;
      div         <= '0;
      rises       <= '0;
      cap         <= '0;
      track_pulse <= 1'b0;
      done        <= 1'b0;
    end else begin
      track_pulse <= 1'b0;
      done        <= 1'b0;
      if (go && !active) begin
        cs_n   <= 1'b0;
        active <= 1'b1;
        div    <= '0;
        rises  <= '0;
        cap    <= '0;
      end else if (active) begin
        if (div == DW'(HALF - 1)) begin
          div <= '0;
          if (sclk) begin
            sclk <= 1'b0;
          end else begin
            sclk  <= 1'b1;
            rises <= rises + EW'(1);
            if (rises < EW'(CAP_W))
              cap <= {cap[CAP_W-2:0], sdata};
            if (rises + EW'(1) == EW'(CAP_W))
              track_pulse <= 1'b1;
            if (rises + EW'(1) == n_edges) begin
              cs_n   <= 1'b1;
              active <= 1'b0;
              done   <= 1'b1;
            end
          end
        end else begin
          div <= div + DW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/adc_sample_reader.sv
module adc_sample_reader
  import adc_rd_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int SCLK_HALF   = 7,
  parameter int FRAME_SCLKS = 20,
  parameter int ACQ_NS      = 350,
  parameter int QUIET_NS    = 50,
  parameter int SHDN_EDGES  = 4,
  parameter int DATA_W      = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              continuous,
  input  logic              low_power,
  output logic              sclk,
  output logic              cs_n,
  input  logic              sdata,
  output logic              busy,
  output logic [DATA_W-1:0] result,
  output logic              result_valid,
  output logic              frame_error
);
  localparam int LEAD       = 3;
  localparam int TRAIL      = 3;
  localparam int CAP_W      = LEAD + DATA_W;
  localparam int WORD       = CAP_W + TRAIL;
  localparam int EW         = $clog2(WORD + 1);
  localparam int ACQ_CLKS   = ns_to_clks(ACQ_NS, CLK_HZ);
  localparam int QUIET_CLKS = ns_to_clks(QUIET_NS, CLK_HZ);
  localparam int FRAME_CLKS = FRAME_SCLKS * 2 * SCLK_HALF;

  frame_kind_e      kind, next_kind;
  logic             pend, shdn_pend, need_dummy;
  logic             go, gate_ok;
  logic             quiet_ok, acq_ok, period_ok;
  logic             track_pulse, eng_done;
  logic [CAP_W-1:0] cap;
  logic [EW-1:0]    n_edges;

  assign next_kind = shdn_pend ? FR_SHDN : (need_dummy ? FR_DUMMY : FR_REAL);
  assign n_edges   = (kind == FR_SHDN) ? EW'(SHDN_EDGES) : EW'(WORD);
  assign gate_ok   = cs_n && !eng_done && quiet_ok && acq_ok && period_ok;
  assign go        = gate_ok && (pend || shdn_pend);
  assign busy      = pend || shdn_pend || !cs_n || eng_done;

  adc_rd_sclk_eng #(
    .HALF  (SCLK_HALF),
    .WORD  (WORD),
    .CAP_W (CAP_W)
  ) u_eng (
    .clk         (clk),
    .rst         (rst),
    .go          (go),
    .n_edges     (n_edges),
    .sdata       (sdata),
    .sclk        (sclk),
    .cs_n        (cs_n),
    .track_pulse (track_pulse),
    .done        (eng_done),
    .cap         (cap)
  );

  adc_rd_sat_timer #(.LIMIT(QUIET_CLKS)) u_quiet (
    .clk (clk), .rst (rst), .clr (eng_done), .done (quiet_ok)
  );

  adc_rd_sat_timer #(.LIMIT(ACQ_CLKS)) u_acq (
    .clk  (clk),
    .rst  (rst),
    .clr  (track_pulse || (eng_done && kind == FR_SHDN)),
    .done (acq_ok)
  );

  adc_rd_sat_timer #(.LIMIT(FRAME_CLKS)) u_period (
    .clk (clk), .rst (rst), .clr (go), .done (period_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      kind         <= FR_REAL;
      pend         <= 1'b0;
      shdn_pend    <= 1'b0;
      need_dummy   <= 1'b1;
      result       <= '0;
      result_valid <= 1'b0;
      frame_error  <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      if (go)
        kind <= next_kind;
      if (!busy && (start || continuous))
        pend <= 1'b1;
      if (eng_done) begin
        case (kind)
          FR_DUMMY: need_dummy <= 1'b0;
          FR_REAL: begin
            result       <= cap[DATA_W-1:0];
            frame_error  <= |cap[CAP_W-1 -: LEAD];
            result_valid <= 1'b1;
            pend         <= continuous;
            if (low_power)
              shdn_pend <= 1'b1;
          end
          FR_SHDN: begin
            shdn_pend  <= 1'b0;
            need_dummy <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_rd_checker.sv
module adc_rd_checker #(
  parameter int QUIET_CLKS = 3,
  parameter int ACQ_CLKS   = 18,
  parameter int FRAME_CLKS = 280,
  parameter int DATA_W     = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              sclk,
  input logic              result_valid,
  input logic              frame_error,
  input logic [DATA_W-1:0] result
);
  int         hi_cnt, acq_cnt, per_cnt;
  logic [4:0] rise_cnt;
  logic       cs_q, sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt   <= QUIET_CLKS;
      acq_cnt  <= ACQ_CLKS;
      per_cnt  <= FRAME_CLKS;
      rise_cnt <= '0;
      cs_q     <= 1'b1;
      sclk_q   <= 1'b1;
    end else begin
      cs_q    <= cs_n;
      sclk_q  <= sclk;
      hi_cnt  <= cs_n ? ((hi_cnt >= QUIET_CLKS) ? hi_cnt : hi_cnt + 1) : 0;
      per_cnt <= (cs_q && !cs_n) ? 0 : ((per_cnt >= FRAME_CLKS) ? per_cnt : per_cnt + 1);
      if (cs_q && !cs_n)        rise_cnt <= '0;
      else if (!sclk_q && sclk) rise_cnt <= rise_cnt + 5'd1;
      acq_cnt <= (!sclk_q && sclk && rise_cnt == 5'd12) ? 0
               : ((acq_cnt >= ACQ_CLKS) ? acq_cnt : acq_cnt + 1);
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cs_n && sclk && !result_valid)); // R1
  AST_CS_FALL_SCLK_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> sclk); // R2
  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sclk); // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> result_valid); // R3
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(frame_error) |-> result_valid); // R4
  AST_QUIET_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> hi_cnt >= QUIET_CLKS); // R5
  AST_ACQ_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> acq_cnt >= ACQ_CLKS); // R6
  AST_FRAME_SPACING: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> per_cnt >= FRAME_CLKS); // R7
endmodule

bind adc_sample_reader adc_rd_checker #(
  .QUIET_CLKS (QUIET_CLKS),
  .ACQ_CLKS   (ACQ_CLKS),
  .FRAME_CLKS (FRAME_CLKS),
  .DATA_W     (DATA_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cs_n         (cs_n),
  .sclk         (sclk),
  .result_valid (result_valid),
  .frame_error  (frame_error),
  .result       (result)
);

// File: tb/tb_adc_sample_reader.sv
module tb_adc_sample_reader;
  localparam int HALF    = 7;
  localparam int FSCLK   = 20;
  localparam int SHDN    = 4;
  localparam int QUIET_C = 3;              // 50 ns at 20 ns per clock
  localparam int ACQ_C   = 18;             // 350 ns at 20 ns per clock
  localparam int FRAME_C = FSCLK * 2 * HALF;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, continuous = 1'b0;
  logic low_power = 1'b0, sdata = 1'b0;
  logic sclk, cs_n, busy, result_valid, frame_error;
  logic [9:0] result;

  always #10 clk = ~clk;

  adc_sample_reader #(
    .CLK_HZ(50_000_000), .SCLK_HALF(HALF), .FRAME_SCLKS(FSCLK),
    .ACQ_NS(350), .QUIET_NS(50), .SHDN_EDGES(SHDN), .DATA_W(10)
  ) dut (
    .clk(clk), .rst(rst), .start(start), .continuous(continuous),
    .low_power(low_power), .sclk(sclk), .cs_n(cs_n), .sdata(sdata),
    .busy(busy), .result(result), .result_valid(result_valid),
    .frame_error(frame_error)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural converter
  logic [9:0]  adc_value = '0;
  bit          force_lead = 1'b0;
  bit          awake = 1'b0;
  int          falls = 0, frames = 0, last_falls = 0;
  logic [15:0] word = '0;

  always @(negedge cs_n) begin
    frames++;
    falls = 0;
    word  = {(force_lead ? 3'b010 : 3'b000), (awake ? adc_value : 10'h2C3), 3'b000};
    sdata <= 1'b0;
  end
  always @(negedge sclk) if (cs_n === 1'b0) begin
    falls++;
    if (falls <= 16) sdata <= word[16 - falls];
  end
  always @(posedge cs_n) begin
    last_falls = falls;
    if (falls >= 10)     awake = 1'b1;
    else if (falls >= 2) awake = 1'b0;
  end

  // scoreboard
  typedef struct { logic [9:0] v; bit e; } exp_t;
  exp_t q[$];
  int n_valid = 0;

  task automatic push_expect(input logic [9:0] v, input bit e);
    exp_t x;
    x.v = v; x.e = e;
    q.push_back(x);
  endtask

  always @(negedge clk) if (!rst && result_valid === 1'b1) begin
    n_valid++;
    if (q.size() == 0) check(1'b0, "R11 unexpected result", int'(result), 0);
    else begin
      exp_t x;
      x = q.pop_front();
      check(result == x.v, "R3 result", int'(result), int'(x.v));
      check(frame_error == x.e, "R4 frame_error", int'(frame_error), int'(x.e));
    end
  end

  // link timing monitor
  int hi_cyc = 1000, per_cyc = 1000, acq_cyc = 1000, rises = 0;
  bit cs_q = 1'b1, sclk_q = 1'b1;

  always @(negedge clk) if (!rst) begin
    if (cs_q && !cs_n) begin
      check(hi_cyc >= QUIET_C, "R5 quiet gap", hi_cyc, QUIET_C);
      check(per_cyc >= FRAME_C, "R7 frame spacing", per_cyc, FRAME_C);
      check(acq_cyc >= ACQ_C, "R6 acquisition gap", acq_cyc, ACQ_C);
      check(sclk === 1'b1, "R2 sclk high at cs fall", int'(sclk), 1);
      per_cyc = 0;
      rises = 0;
    end
    hi_cyc = cs_n ? hi_cyc + 1 : 0;
    per_cyc++;
    if (!sclk_q && sclk) begin
      rises++;
      if (rises == 13) acq_cyc = 0;
    end
    acq_cyc++;
    cs_q = cs_n;
    sclk_q = sclk;
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R11 watchdog actual=busy expected=idle");
      summary();
      $finish;
    end
  end

  initial begin
    int f0, v0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cs_n === 1'b1, "R1 cs_n after reset", int'(cs_n), 1);
    check(sclk === 1'b1, "R1 sclk after reset", int'(sclk), 1);
    check(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
    check(result_valid === 1'b0, "R1 valid after reset", int'(result_valid), 0);

    // R8: first read after reset needs a dummy frame
    adc_value = 10'h2A5; f0 = frames;
    push_expect(10'h2A5, 1'b0);
    pulse_start();
    wait_idle();
    check(frames - f0 == 2, "R8 frames after reset", frames - f0, 2);
    check(last_falls == 16, "R2 falling edges per frame", last_falls, 16);

    // R3: extreme codes, one frame each
    foreach (q[i]) ; // queue is empty here
    for (int k = 0; k < 2; k++) begin
      adc_value = (k == 0) ? 10'h000 : 10'h3FF;
      f0 = frames;
      push_expect(adc_value, 1'b0);
      pulse_start();
      wait_idle();
      check(frames - f0 == 1, "R3 single frame when awake", frames - f0, 1);
    end

    // R4: nonzero leading bit, then clean frame clears the flag
    force_lead = 1'b1; adc_value = 10'h155;
    push_expect(10'h155, 1'b1);
    pulse_start();
    wait_idle();
    force_lead = 1'b0; adc_value = 10'h0AA;
    push_expect(10'h0AA, 1'b0);
    pulse_start();
    wait_idle();

    // R11: start while busy is ignored
    adc_value = 10'h1E1; f0 = frames; v0 = n_valid;
    push_expect(10'h1E1, 1'b0);
    pulse_start();
    repeat (40) @(negedge clk);
    check(busy === 1'b1, "R11 busy during frame", int'(busy), 1);
    pulse_start();
    wait_idle();
    check(frames - f0 == 1, "R11 extra start ignored (frames)", frames - f0, 1);
    check(n_valid - v0 == 1, "R11 extra start ignored (results)", n_valid - v0, 1);

    // R10: continuous sampling
    adc_value = 10'h1C7; f0 = frames; v0 = n_valid;
    for (int k = 0; k < 4; k++) push_expect(10'h1C7, 1'b0);
    @(negedge clk) continuous = 1'b1;
    while (n_valid < v0 + 3) @(negedge clk);
    continuous = 1'b0;
    wait_idle();
    check(n_valid - v0 == 4, "R10 continuous results", n_valid - v0, 4);
    check(frames - f0 == 4, "R10 continuous frames", frames - f0, 4);

    // R9: low power from awake state, then R8 dummy after shutdown
    low_power = 1'b1; adc_value = 10'h0F0; f0 = frames;
    push_expect(10'h0F0, 1'b0);
    pulse_start();
    wait_idle();
    check(frames - f0 == 2, "R9 real plus shutdown frames", frames - f0, 2);
    check(last_falls == SHDN, "R9 shutdown frame edges", last_falls, SHDN);
    check(awake == 1'b0, "R9 converter asleep", int'(awake), 0);
    adc_value = 10'h30C; f0 = frames;
    push_expect(10'h30C, 1'b0);
    pulse_start();
    wait_idle();
    check(frames - f0 == 3, "R8 dummy after shutdown", frames - f0, 3);
    check(last_falls == SHDN, "R9 second shutdown edges", last_falls, SHDN);

    check(q.size() == 0, "R3 all expected results delivered", q.size(), 0);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule